// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the digital receive side of a 10-bit serial-input digital-to-analog converter. A host drives three wires into it: a serial clock, an active-low select and a data line. While the select is asserted, each rising serial clock edge moves one data bit into a 16-bit shift register, most significant bit first. When the select is released, the low twelve bits of that register are taken as the converter word. The upper ten of those twelve bits become the converter code, and a one-cycle strobe marks each update.

The pins are asynchronous to the block. They are brought into a faster system clock through flip-flop synchronisers, and every serial clock and select edge is found by comparing successive synchronised samples. The host may send either a 12-bit frame or a 16-bit frame. A 12-bit frame holds ten code bits followed by two sub-LSB bits. A 16-bit frame puts four don't-care bits in front of those twelve.

A serial output pin presents the bit leaving the top of the shift register. It moves on falling serial clock edges while the block is selected, so several devices can be chained output-to-input. While the block is deselected, that pin stays driven at its last value. Reset clears the code to zero.

Top module: `sdac_frontend`

## Requirements
- R1: While select is low, each rising serial clock edge shifts the data pin into bit 0 of the 16-bit shift register, and every other bit moves up one place. The first bit sent therefore ends up highest.
- R2: A rising edge of select loads bits 11 down to 2 of the shift register onto `code_o`. `code_o` changes at no other time.
- R3: While select is high, serial clock edges leave the shift register unchanged. A select pulse with no serial clock edges inside it reloads the previous code.
- R4: A 12-bit frame (ten code bits MSB first, then two sub-LSB bits) yields exactly those ten code bits on `code_o`.
- R5: In a 16-bit frame, the four leading bits have no effect on `code_o`.
- R6: `ser_dout_o` changes only on a falling serial clock edge while selected. At that edge it takes bit 15 of the shift register, so a data bit reappears on it at the falling edge that follows its sixteenth rising edge.
- R7: While select is high, `ser_dout_o` keeps its last value and stays driven.
- R8: After reset, `code_o` is 0, `update_o` is 0 and `ser_dout_o` is 0.
- R9: `update_o` is high for exactly one system clock per select rising edge and at no other time.
- R10: The two sub-LSB bits of a frame never affect `code_o`.
- R11: If select rises in the same system cycle as a falling serial clock edge, both the code load and the serial output update take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_sel_n_i | input | 1 | Active-low select from the host |
| ser_din_i | input | 1 | Serial data in |
| ser_dout_o | output | 1 | Serial data out for chaining |
| code_o | output | 10 | Latched converter code |
| update_o | output | 1 | One-cycle pulse when `code_o` is loaded |

## Verification
The code load on a select release and the serial output step on a falling serial clock can fall in the same system cycle. The bench provokes this by dropping the serial clock and raising select in a single drive at the end of a frame. It judges the result two ways: the code popped from the scoreboard must equal the frame's code bits, and the serial output must equal bit 15 of the bench's own shift model after that frame's last rising edge. On every other frame, the serial output is also compared with that model after each falling edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   // index of each serial pin inside the synchroniser bus
   localparam int unsigned IDX_SCLK = 0;
   localparam int unsigned IDX_SEL  = 1;
   localparam int unsigned IDX_DIN  = 2;
   localparam int unsigned PIN_CNT  = 3;
   localparam int unsigned CTL_CNT  = 2;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int unsigned     WIDTH   = 3,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] now_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdac_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign now_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
   parameter int unsigned      WIDTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] now_i,
   output logic [WIDTH-1:0] prev_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= RST_VAL;
      else        prev_o <= now_i;
   end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
   import sdac_pkg::*;
#(
   parameter int unsigned SHIFT_W = 16,
   parameter int unsigned WIN_HI  = 11,
   parameter int unsigned WIN_LO  = 2,
   localparam int unsigned WIN_W  = WIN_HI - WIN_LO + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  edge_t            sclk_evt_i,
   input  logic             din_i,
   output logic [WIN_W-1:0] win_o,
   output logic             dout_o
);
   if (SHIFT_W < 2 || WIN_HI >= SHIFT_W || WIN_LO > WIN_HI) begin : g_bad_win
      $error("sdac_shifter: window does not fit the shift register");
   end

   logic [SHIFT_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         dout_o <= 1'b0;
      end else begin
         if (sel_i && sclk_evt_i.rise) sr_q   <= {sr_q[SHIFT_W-2:0], din_i};
         if (sel_i && sclk_evt_i.fall) dout_o <= sr_q[SHIFT_W-1];
      end
   end

   assign win_o = sr_q[WIN_HI:WIN_LO];

   // R1
   shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && sclk_evt_i.rise) |=> (sr_q[0] == $past(din_i)));
   // R3
   shift_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> $stable(sr_q));
   // R7
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> $stable(dout_o));
   // R6
   dout_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_o) |-> $past(sclk_evt_i.fall));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] word_i,
   output logic [CODE_W-1:0] code_o,
   output logic              upd_o
);
   if (CODE_W < 1) begin : g_bad_code
      $error("sdac_latch: CODE_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         upd_o  <= 1'b0;
      end else begin
         upd_o <= load_i;
         if (load_i) code_o <= word_i;
      end
   end

   // R9
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);
   // R2
   code_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> upd_o);
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
   import sdac_pkg::*;
#(
   parameter int unsigned SHIFT_W     = 16,
   parameter int unsigned CODE_W      = 10,
   parameter int unsigned SUB_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_sel_n_i,
   input  logic              ser_din_i,
   output logic              ser_dout_o,
   output logic [CODE_W-1:0] code_o,
   output logic              update_o
);
   localparam int unsigned REG_W = CODE_W + SUB_W;
   localparam logic [PIN_CNT-1:0] SYNC_RST = {{(PIN_CNT-1){1'b0}}, 1'b1} << IDX_SEL;
   localparam logic [CTL_CNT-1:0] CTL_RST  = SYNC_RST[CTL_CNT-1:0];

   if (REG_W > SHIFT_W) begin : g_bad_reg
      $error("sdac_frontend: code plus sub-LSB bits exceed the shift register");
   end

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_now;
   logic [CTL_CNT-1:0] ctl_prev;
   edge_t              sclk_evt;
   logic               sel_active;
   logic               sel_release;
   logic [CODE_W-1:0]  code_win;

   assign pins_raw[IDX_SCLK] = ser_clk_i;
   assign pins_raw[IDX_SEL]  = ser_sel_n_i;
   assign pins_raw[IDX_DIN]  = ser_din_i;

   sdac_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_raw),
      .now_o   (pins_now)
   );

   sdac_edge #(.WIDTH(CTL_CNT), .RST_VAL(CTL_RST)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .now_i  (pins_now[CTL_CNT-1:0]),
      .prev_o (ctl_prev)
   );

   assign sclk_evt.rise = pins_now[IDX_SCLK] & ~ctl_prev[IDX_SCLK];
   assign sclk_evt.fall = ~pins_now[IDX_SCLK] & ctl_prev[IDX_SCLK];
   // selection judged on the earlier sample so a release and a clock edge in one cycle both count
   assign sel_active    = ~ctl_prev[IDX_SEL];
   assign sel_release   = pins_now[IDX_SEL] & ~ctl_prev[IDX_SEL];

   sdac_shifter #(.SHIFT_W(SHIFT_W), .WIN_HI(REG_W-1), .WIN_LO(SUB_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel_active),
      .sclk_evt_i (sclk_evt),
      .din_i      (pins_now[IDX_DIN]),
      .win_o      (code_win),
      .dout_o     (ser_dout_o)
   );

   sdac_latch #(.CODE_W(CODE_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (sel_release),
      .word_i (code_win),
      .code_o (code_o),
      .upd_o  (update_o)
   );
endmodule

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb_top;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       sel_n = 1'b1;
   logic       din = 1'b0;
   logic       dout;
   logic [9:0] code;
   logic       upd;

   int total = 0;
   int bad = 0;
   int strobes = 0;
   int pushes = 0;
   bit done = 1'b0;
   bit upd_d = 1'b0;

   logic [9:0]  exp_q [$];
   string       tag_q [$];
   logic [15:0] model_sr = '0;
   logic        model_dout = 1'b0;

   always #5 clk = ~clk;

   sdac_frontend dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk_i   (sclk),
      .ser_sel_n_i (sel_n),
      .ser_din_i   (din),
      .ser_dout_o  (dout),
      .code_o      (code),
      .update_o    (upd)
   );

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (upd) begin
            strobes++;
            check(!upd_d, "R9 strobe wider than one cycle", 1, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 strobe with nothing expected", int'(code), 0);
            end else begin
               automatic logic [9:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(code === e, t, int'(code), int'(e));
            end
         end
         upd_d = upd;
      end
   end

   // driver side: sends n bits of word (MSB first) and pushes the expected code
   task automatic send_frame(input logic [15:0] word, input int n, input logic [9:0] expc,
                             input bit simul, input string tag);
      sel_n = 1'b0;
      w(HALF);
      for (int i = n - 1; i >= 0; i--) begin
         din = word[i];
         w(HALF);
         sclk = 1'b1;
         model_sr = {model_sr[14:0], word[i]};
         w(HALF);
         if (i == 0 && simul) begin
            exp_q.push_back(expc); tag_q.push_back(tag); pushes++;
            sclk = 1'b0;
            sel_n = 1'b1;
            model_dout = model_sr[15];
            w(HALF);
            // R11 serial output still advanced on the shared cycle
            check(dout === model_dout, "R11 dout on shared cycle", int'(dout), int'(model_dout));
         end else begin
            sclk = 1'b0;
            model_dout = model_sr[15];
            w(HALF);
            // R6 serial output equals bit 15 after the falling edge
            check(dout === model_dout, "R6 dout after falling edge", int'(dout), int'(model_dout));
         end
      end
      if (!simul) begin
         exp_q.push_back(expc); tag_q.push_back(tag); pushes++;
         sel_n = 1'b1;
      end
      w(3 * HALF);
   endtask

   task automatic idle_toggle(input int n);
      automatic logic held = dout;
      for (int i = 0; i < n; i++) begin
         din = i[0];
         w(HALF);
         sclk = 1'b1;
         w(HALF);
         sclk = 1'b0;
         w(HALF);
         // R7 serial output held while deselected
         check(dout === held, "R7 dout held while deselected", int'(dout), int'(held));
      end
   endtask

   initial begin
      w(3);
      // R8 reset values
      check(code === 10'h000, "R8 code at reset", int'(code), 0);
      check(upd === 1'b0, "R8 strobe at reset", int'(upd), 0);
      check(dout === 1'b0, "R8 dout at reset", int'(dout), 0);
      rst_n = 1'b1;
      w(6);
      check(code === 10'h000, "R8 code after reset release", int'(code), 0);

      // R5 R1 sixteen-bit frame, leading bits nonzero
      send_frame({4'hA, 10'h2C5, 2'b00}, 16, 10'h2C5, 1'b0, "R5 sixteen-bit frame");
      // R4 twelve-bit frame
      send_frame({4'h0, 10'h13A, 2'b00}, 12, 10'h13A, 1'b0, "R4 twelve-bit frame");
      // R7 R3 clocks while deselected
      idle_toggle(6);
      // R3 empty select pulse reloads the untouched register
      send_frame(16'h0000, 0, 10'h13A, 1'b0, "R3 shift register untouched while deselected");
      // R10 sub-LSB ones do not leak into the code
      send_frame({4'h5, 10'h001, 2'b11}, 16, 10'h001, 1'b0, "R10 sub-LSB bits ignored");
      // R11 select release on the same cycle as a falling edge
      send_frame({4'h3, 10'h255, 2'b00}, 16, 10'h255, 1'b1, "R11 code on shared cycle");
      // R1 R2 all-ones then a twelve-bit frame with only the MSB set
      send_frame(16'hFFFC, 16, 10'h3FF, 1'b0, "R2 all-ones code");
      send_frame({4'h0, 10'h200, 2'b00}, 12, 10'h200, 1'b0, "R1 MSB-first order");
      idle_toggle(3);

      w(20);
      // R9 one strobe per release
      check(strobes == pushes, "R9 strobe count", strobes, pushes);
      check(exp_q.size() == 0, "R2 pending expected codes", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule